// File: doc/BRIEF.md
# Double-Word Field Extract and Insert Unit

This block carries out one field operation per accepted request on two data words, a left word and a right word. The two words are joined into a double word with the left word in the upper half. The double word is shifted left by a shift count, and the upper half of the result becomes the shifter value. A mask is then built with a set number of ones starting at bit 0. In extract mode the result is the shifter value ANDed with the mask. In insert mode the mask first loses its lowest shift-count bits. Each result bit then comes from the shifter value where the mask is one and from the right word where it is zero.

One datapath covers both field extraction and field deposit. An extract uses the shift to bring a field down toward bit 0. An insert uses it to move a value up into place over an existing word. Each request is a pulse on the input valid with its descriptor and operands. The result comes back one cycle later with its own valid strobe. Between requests the result register keeps its last value.

Top module: `fieldUnit`

## Requirements
- R1: After reset, `outValid` is 0 and `result` is all zeros.
- R2: `outValid` in every cycle equals the value `inValid` had one clock edge earlier.
- R3: On an edge where `inValid` is 0, `result` keeps its value, whatever the other inputs do.
- R4: In extract mode (`insertEn` = 0), `result` bit i is bit (i + DATA_W - `shiftAmt`) of the double word {`leftWord`,`rightWord`} (left word in the upper half) if i < `maskWidth`, and 0 otherwise.
- R5: A `maskWidth` of DATA_W or more (32 to 63 by default) gives a mask of all ones.
- R6: A `maskWidth` of 0 makes the result 0 in extract mode and equal to `rightWord` in insert mode.
- R7: In insert mode (`insertEn` = 1), a mask bit i is 1 only when i < `maskWidth` and i >= `shiftAmt`. `result` bit i takes the shifter bit where the mask is 1 and `rightWord` bit i where it is 0.
- R8: In extract mode, every `result` bit at position `maskWidth` or above is 0.
- R9: With `shiftAmt` = 0, the shifter value equals `leftWord`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| inValid | input | 1 | Request strobe; the descriptor and operands are taken on this edge |
| shiftAmt | input | SHIFT_W (5) | Left shift count for the double word |
| maskWidth | input | SHIFT_W+1 (6) | Number of mask ones, counted from bit 0 |
| insertEn | input | 1 | 1 = insert (merge over `rightWord`), 0 = extract |
| leftWord | input | DATA_W (32) | Upper half of the double word |
| rightWord | input | DATA_W (32) | Lower half of the double word, and the merge background |
| outValid | output | 1 | Result strobe, one cycle after `inValid` |
| result | output | DATA_W (32) | Registered field result |

## Verification
The bench uses the default DATA_W of 32. This gives a 5-bit shift count and a 6-bit mask width field, so widths from 33 to 63 can be driven and the saturation of the mask can be observed. The full shift range 0 to 31 can also be reached, including shift counts larger than the mask width, where insert mode leaves the right word unchanged. Expected results come from a bit-by-bit model that computes each output bit from its position.

// File: rtl/fieldPkg.sv
package fieldPkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic capture;   // load a new result on this edge
  } fieldStrobes_t;
endpackage

// File: rtl/fieldControl.sv
module fieldControl
  import fieldPkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  output fieldStrobes_t strobes,
  output logic          outValid
);
  always_comb begin
    strobes.capture = inValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end
endmodule

// File: rtl/fieldDatapath.sv
module fieldDatapath
  import fieldPkg::*;
#(
  parameter int DATA_W  = 32,
  localparam int SHIFT_W = $clog2(DATA_W),
  localparam int MASK_W  = SHIFT_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  fieldStrobes_t     strobes,
  input  logic [SHIFT_W-1:0] shiftAmt,
  input  logic [MASK_W-1:0]  maskWidth,
  input  logic              insertEn,
  input  logic [DATA_W-1:0] leftWord,
  input  logic [DATA_W-1:0] rightWord,
  output logic [DATA_W-1:0] result
);
  logic [2*DATA_W-1:0] pairShifted;
  logic [DATA_W-1:0]   shifted;
  logic [DATA_W-1:0]   widthMask;
  logic [DATA_W-1:0]   fieldMask;
  logic [DATA_W-1:0]   nextResult;

  // Funnel shift: keep the upper half of the shifted pair
  assign pairShifted = {leftWord, rightWord} << shiftAmt;
  assign shifted     = pairShifted[2*DATA_W-1:DATA_W];

  // Per-bit mask: width compare, trimmed by shift count when inserting
  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign widthMask[i] = (MASK_W'(i) < maskWidth);
    assign fieldMask[i] = widthMask[i] & (~insertEn | (SHIFT_W'(i) >= shiftAmt));
  end

  always_comb begin
    if (insertEn) nextResult = (fieldMask & shifted) | (~fieldMask & rightWord);
    else          nextResult = fieldMask & shifted;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                result <= '0;
    else if (strobes.capture) result <= nextResult;
  end
endmodule

// File: rtl/fieldUnit.sv
module fieldUnit
  import fieldPkg::*;
#(
  parameter int DATA_W  = 32,
  localparam int SHIFT_W = $clog2(DATA_W),
  localparam int MASK_W  = SHIFT_W + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [SHIFT_W-1:0] shiftAmt,
  input  logic [MASK_W-1:0]  maskWidth,
  input  logic               insertEn,
  input  logic [DATA_W-1:0]  leftWord,
  input  logic [DATA_W-1:0]  rightWord,
  output logic               outValid,
  output logic [DATA_W-1:0]  result
);
  fieldStrobes_t strobes;

  fieldControl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobes  (strobes),
    .outValid (outValid)
  );

  fieldDatapath #(.DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .shiftAmt  (shiftAmt),
    .maskWidth (maskWidth),
    .insertEn  (insertEn),
    .leftWord  (leftWord),
    .rightWord (rightWord),
    .result    (result)
  );
endmodule

// File: rtl/fieldUnitChecker.sv
module fieldUnitChecker #(
  parameter int DATA_W  = 32,
  localparam int SHIFT_W = $clog2(DATA_W),
  localparam int MASK_W  = SHIFT_W + 1
) (
  input logic               clk,
  input logic               rstN,
  input logic               inValid,
  input logic [SHIFT_W-1:0] shiftAmt,
  input logic [MASK_W-1:0]  maskWidth,
  input logic               insertEn,
  input logic [DATA_W-1:0]  leftWord,
  input logic [DATA_W-1:0]  rightWord,
  input logic               outValid,
  input logic [DATA_W-1:0]  result
);
  localparam logic [DATA_W-1:0] ONES = '1;

  AST_RESET_STATE: assert property (@(posedge clk) !rstN |-> (!outValid && result == '0)); // R1
  AST_VALID_FOLLOW: assert property (@(posedge clk) disable iff (!rstN) inValid |=> outValid); // R2
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rstN) !inValid |=> !outValid); // R2
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rstN) !inValid |=> $stable(result)); // R3
  AST_EXTRACT_ZERO_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !insertEn && maskWidth == '0) |=> result == '0); // R6
  AST_INSERT_ZERO_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && insertEn && maskWidth == '0) |=> result == $past(rightWord)); // R6
  AST_INSERT_LOW_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && insertEn) |=> ((result ^ $past(rightWord)) & ~(ONES << $past(shiftAmt))) == '0); // R7
  AST_EXTRACT_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !insertEn && maskWidth < MASK_W'(DATA_W)) |=> (result >> $past(maskWidth)) == '0); // R8
  AST_PLAIN_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !insertEn && shiftAmt == '0 && maskWidth >= MASK_W'(DATA_W)) |=> result == $past(leftWord)); // R9
endmodule

bind fieldUnit fieldUnitChecker #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/fieldUnit_tb.sv
module fieldUnit_tb;
  localparam int DATA_W  = 32;
  localparam int SHIFT_W = $clog2(DATA_W);
  localparam int MASK_W  = SHIFT_W + 1;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               inValid = 1'b0;
  logic [SHIFT_W-1:0] shiftAmt = '0;
  logic [MASK_W-1:0]  maskWidth = '0;
  logic               insertEn = 1'b0;
  logic [DATA_W-1:0]  leftWord = '0;
  logic [DATA_W-1:0]  rightWord = '0;
  logic               outValid;
  logic [DATA_W-1:0]  result;

  int checks = 0;
  int errors = 0;

  fieldUnit #(.DATA_W(DATA_W)) u_dut (.*);

  always #4 clk = ~clk;

  function automatic logic [DATA_W-1:0] model(input logic [DATA_W-1:0] l, input logic [DATA_W-1:0] r,
                                              input int sh, input int w, input logic ins);
    logic [2*DATA_W-1:0] pair = {l, r};
    logic [DATA_W-1:0] o;
    for (int i = 0; i < DATA_W; i++) begin
      logic sbit = pair[i + DATA_W - sh];
      logic m = (i < w) && (!ins || i >= sh);
      o[i] = m ? sbit : (ins ? r[i] : 1'b0);
    end
    return o;
  endfunction

  task automatic check(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One request; checks outValid and result one cycle later
  task automatic runOp(input string req, input logic [DATA_W-1:0] l, input logic [DATA_W-1:0] r,
                       input int sh, input int w, input logic ins);
    leftWord = l; rightWord = r; shiftAmt = SHIFT_W'(sh);
    maskWidth = MASK_W'(w); insertEn = ins; inValid = 1'b1;
    @(posedge clk); @(negedge clk);
    inValid = 1'b0;
    check({req, " R2 valid"}, DATA_W'(outValid), DATA_W'(1));
    check(req, result, model(l, r, sh, w, ins));
  endtask

  task automatic testReset;
    check("R1 outValid", DATA_W'(outValid), '0);
    check("R1 result", result, '0);
  endtask

  task automatic testExtract;
    runOp("R4 extract mid", 32'hDEADBEEF, 32'h12345678, 8, 12, 1'b0);
    runOp("R4 extract hi shift", 32'hA5A5F00F, 32'hC3C3_0FF0, 31, 20, 1'b0);
    runOp("R8 extract upper zero", 32'hFFFFFFFF, 32'hFFFFFFFF, 3, 7, 1'b0);
    check("R8 above width", result >> 7, '0);
  endtask

  task automatic testSaturate;
    runOp("R5 width 32", 32'h13579BDF, 32'h2468ACE0, 4, 32, 1'b0);
    runOp("R5 width 63", 32'h13579BDF, 32'h2468ACE0, 4, 63, 1'b0);
    check("R5 wide equals shifter", result, {32'h3579BDF2});
  endtask

  task automatic testZeroWidth;
    runOp("R6 extract zero", 32'hFFFFFFFF, 32'h0F0F0F0F, 5, 0, 1'b0);
    check("R6 extract zero value", result, '0);
    runOp("R6 insert zero", 32'hFFFFFFFF, 32'h0F0F0F0F, 5, 0, 1'b1);
    check("R6 insert keeps right", result, 32'h0F0F0F0F);
  endtask

  task automatic testInsert;
    runOp("R7 insert", 32'h000000AB, 32'h11111111, 8, 16, 1'b1);
    check("R7 insert value", result, 32'h1111AB11);
    runOp("R7 insert shift beyond width", 32'hFFFFFFFF, 32'h55555555, 20, 10, 1'b1);
    runOp("R7 insert full", 32'h0000FFFF, 32'hAAAAAAAA, 16, 40, 1'b1);
  endtask

  task automatic testNoShift;
    runOp("R9 shift zero", 32'hCAFEF00D, 32'h87654321, 0, 32, 1'b0);
    check("R9 equals left", result, 32'hCAFEF00D);
  endtask

  task automatic testHold;
    logic [DATA_W-1:0] held = result;
    leftWord = 32'h0; rightWord = 32'hFFFFFFFF; maskWidth = 6'd0; insertEn = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R3 hold result", result, held);
    check("R2 idle valid", DATA_W'(outValid), '0);
  endtask

  task automatic testBackToBack;
    leftWord = 32'h0000_00F0; rightWord = '0; shiftAmt = 5'd4; maskWidth = 6'd8;
    insertEn = 1'b0; inValid = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R4 b2b first", result, model(32'h0000_00F0, '0, 4, 8, 1'b0));
    leftWord = 32'h1; rightWord = 32'h8000_0000; shiftAmt = 5'd1; maskWidth = 6'd2;
    @(posedge clk); @(negedge clk);
    inValid = 1'b0;
    check("R2 b2b valid", DATA_W'(outValid), DATA_W'(1));
    check("R4 b2b second", result, 32'h3);
  endtask

  initial begin
    fork
      begin
        #2000000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
      begin
        @(negedge clk);
        testReset();
        @(negedge clk);
        rstN = 1'b1;
        @(negedge clk);
        testReset();
        testExtract();
        testSaturate();
        testZeroWidth();
        testInsert();
        testNoShift();
        testHold();
        testBackToBack();
        testHold();
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule